// File: doc/BRIEF.md
# Link Controller Bring-Up Sequencer

This block drives the ordered power, reset, reference-clock and clock-enable signals that take a serial link controller and its PHY from reset to a trained link. A `start` pulse while idle begins the sequence. The block first puts the PHY and endpoint into a known reset condition. It holds the endpoint in reset for a timed interval, then powers and clocks everything up in a fixed order. After a settle interval it waits for a "setup complete" indication, which stands in for the controller's own register programming. Only then does it enable link training.

Once training is enabled, the block samples `link_up` at a fixed tick interval for a bounded number of tries. It ends each run with a one-cycle `done` pulse. On failure it also raises `link_fail`, and the number of unsuccessful samples is reported. Every duration is counted in pulses of the external `tick` input, so a simulation can use short intervals and silicon can use real ones.

All outputs are registered, and the sequence advances at most one step per clock cycle. After `done`, every output keeps its brought-up value until the next `start`.

Top module: `bringup_seq`

## Requirements
- R1: Under synchronous reset the outputs are `phy_test_pd`=0, `refclk_en`=0, `ep_rst_n`=1, `ep_pwr_en`=0, `train_en`=0, `clk_en`=0, `done`=0, `link_fail`=0 and `retry_cnt`=0.
- R2: The clock edge that accepts `start` in idle clears `link_fail` and `retry_cnt`. Reset entry then takes one clock each, in this order:
  - `phy_test_pd` goes to 1;
  - `train_en` goes to 0;
  - `refclk_en` goes to 0;
  - `ep_rst_n` goes to 0.
- R3: `ep_rst_n` stays low until HOLD_TICKS `tick` pulses have been seen after it fell. It then goes high one clock after the edge that counts the last of those pulses.
- R4: After the reset release, power-up takes one clock each, in this order: `ep_pwr_en` goes to 1, `phy_test_pd` goes to 0, `refclk_en` goes to 1.
- R5: The `clk_en` bits then switch on one per clock from bit 0 to bit NUM_CLKS-1: bit 0 is the reference mux select, bit 1 the 125 MHz reference, bit 2 the output gate, bit 3 the bus clock. A settle wait of SETTLE_TICKS `tick` pulses follows.
- R6: After the settle wait, `train_en` goes high on the first clock edge at which `setup_done` is high, and never while `setup_done` is low.
- R7: With training enabled, `link_up` is sampled on every POLL_TICKS-th `tick` pulse. A high sample ends the run with a one-cycle `done` pulse, `link_fail`=0, and `retry_cnt` equal to the number of low samples before it.
- R8: After MAX_TRIES low samples, `link_fail` goes to 1 together with a one-cycle `done` pulse, and `retry_cnt` equals MAX_TRIES. All other outputs keep their brought-up values.
- R9: `start` has no effect while a run is in progress. A `start` after completion runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (accepted only when idle) |
| tick | input | 1 | Timebase pulse; all durations count these |
| setup_done | input | 1 | Controller setup has completed |
| link_up | input | 1 | Link-up status from the controller |
| phy_test_pd | output | 1 | PHY test power-down |
| refclk_en | output | 1 | PHY reference clock enable |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| ep_pwr_en | output | 1 | Endpoint power enable |
| train_en | output | 1 | Link-training enable |
| clk_en | output | NUM_CLKS | Clock-enable group, thermometer from bit 0 |
| done | output | 1 | One-cycle end-of-run pulse |
| link_fail | output | 1 | Link never came up within MAX_TRIES samples |
| retry_cnt | output | $clog2(MAX_TRIES+1) | Number of low link samples in the current run |

## Verification
Each ordered step shows on its output exactly one clock after the edge at which the previous step showed. The start edge counts as the step before reset entry. A timed wait ends on the edge that counts its final `tick`, so the next output changes one clock after that edge. `train_en` rises on the same edge that sees `setup_done` high. `done`, `link_fail` and `retry_cnt` change on the edge that takes the deciding `link_up` sample. The bench keeps a queue of pending steps that its behavioural model consumes at each rising edge. Every output is compared with that model at the falling edge that follows, so each result is checked in the exact cycle it is due.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PD_ON,
    ST_TRN_OFF,
    ST_REF_OFF,
    ST_RST_LO,
    ST_HOLD,
    ST_RST_HI,
    ST_PWR_ON,
    ST_PD_OFF,
    ST_REF_ON,
    ST_CLKS,
    ST_SETTLE,
    ST_SETUP,
    ST_POLL
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/bringup_tick_timer.sv
module bringup_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  // Fires on the tick that completes the interval; restarts counting after it.
  assign expire = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bringup_retry_ctr.sv
module bringup_retry_ctr #(
  parameter int MAX_TRIES = 10,
  localparam int W = $clog2(MAX_TRIES + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         miss,
  output logic         last_miss,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] LAST = W'(MAX_TRIES - 1);

  assign last_miss = miss && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (miss) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/bringup_clk_chain.sv
module bringup_clk_chain #(
  parameter int NUM_CLKS = 4,
  localparam int IW = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output logic                last,
  output logic [NUM_CLKS-1:0] en
);

  logic [IW-1:0] idx;

  assign last = step && (idx == IW'(NUM_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || last) begin
      idx <= '0;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end

  // One enable per stage; once set it stays set until reset.
  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        en[g] <= 1'b0;
      end else if (step && idx == IW'(g)) begin
        en[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
  import bringup_pkg::*;
#(
  parameter int HOLD_TICKS   = 8,
  parameter int SETTLE_TICKS = 3,
  parameter int POLL_TICKS   = 4,
  parameter int MAX_TRIES    = 10,
  parameter int NUM_CLKS     = 4,
  localparam int RETRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                tick,
  input  logic                setup_done,
  input  logic                link_up,
  output logic                phy_test_pd,
  output logic                refclk_en,
  output logic                ep_rst_n,
  output logic                ep_pwr_en,
  output logic                train_en,
  output logic [NUM_CLKS-1:0] clk_en,
  output logic                done,
  output logic                link_fail,
  output logic [RETRY_W-1:0]  retry_cnt
);

  localparam int LONGEST = max3(HOLD_TICKS, SETTLE_TICKS, POLL_TICKS);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  seq_state_t       state;
  logic             tmr_run;
  logic [CNT_W-1:0] tmr_limit;
  logic             tmr_exp;
  logic             clk_step;
  logic             clk_last;
  logic             accept;
  logic             sample;
  logic             miss;
  logic             last_miss;

  assign accept   = (state == ST_IDLE) && start;
  assign clk_step = (state == ST_CLKS);
  assign sample   = (state == ST_POLL) && tmr_exp;
  assign miss     = sample && !link_up;

  always_comb begin
    tmr_run   = 1'b0;
    tmr_limit = CNT_W'(POLL_TICKS);
    unique case (state)
      ST_HOLD: begin
        tmr_run   = 1'b1;
        tmr_limit = CNT_W'(HOLD_TICKS);
      end
      ST_SETTLE: begin
        tmr_run   = 1'b1;
        tmr_limit = CNT_W'(SETTLE_TICKS);
      end
      ST_POLL: begin
        tmr_run   = 1'b1;
        tmr_limit = CNT_W'(POLL_TICKS);
      end
      default: ;
    endcase
  end

  bringup_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (tmr_run),
    .tick   (tick),
    .limit  (tmr_limit),
    .expire (tmr_exp)
  );

  bringup_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .miss      (miss),
    .last_miss (last_miss),
    .count     (retry_cnt)
  );

  bringup_clk_chain #(.NUM_CLKS(NUM_CLKS)) u_clks (
    .clk  (clk),
    .rst  (rst),
    .step (clk_step),
    .last (clk_last),
    .en   (clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phy_test_pd <= 1'b0;
      refclk_en   <= 1'b0;
      ep_rst_n    <= 1'b1;
      ep_pwr_en   <= 1'b0;
      train_en    <= 1'b0;
      done        <= 1'b0;
      link_fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            link_fail <= 1'b0;
            state     <= ST_PD_ON;
          end
        end
        ST_PD_ON: begin
          phy_test_pd <= 1'b1;
          state       <= ST_TRN_OFF;
        end
        ST_TRN_OFF: begin
          train_en <= 1'b0;
          state    <= ST_REF_OFF;
        end
        ST_REF_OFF: begin
          refclk_en <= 1'b0;
          state     <= ST_RST_LO;
        end
        ST_RST_LO: begin
          ep_rst_n <= 1'b0;
          state    <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_exp) state <= ST_RST_HI;
        end
        ST_RST_HI: begin
          ep_rst_n <= 1'b1;
          state    <= ST_PWR_ON;
        end
        ST_PWR_ON: begin
          ep_pwr_en <= 1'b1;
          state     <= ST_PD_OFF;
        end
        ST_PD_OFF: begin
          phy_test_pd <= 1'b0;
          state       <= ST_REF_ON;
        end
        ST_REF_ON: begin
          refclk_en <= 1'b1;
          state     <= ST_CLKS;
        end
        ST_CLKS: begin
          if (clk_last) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_exp) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_done) begin
            train_en <= 1'b1;
            state    <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (sample) begin
            if (link_up) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (last_miss) begin
              done      <= 1'b1;
              link_fail <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bringup_seq_checker.sv
module bringup_seq_checker #(
  parameter int MAX_TRIES = 10,
  parameter int NUM_CLKS  = 4,
  localparam int RETRY_W  = $clog2(MAX_TRIES + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                setup_done,
  input logic                phy_test_pd,
  input logic                refclk_en,
  input logic                ep_rst_n,
  input logic                ep_pwr_en,
  input logic                train_en,
  input logic [NUM_CLKS-1:0] clk_en,
  input logic                done,
  input logic                link_fail,
  input logic [RETRY_W-1:0]  retry_cnt
);

  logic [NUM_CLKS-1:0] clk_en_inc;
  assign clk_en_inc = clk_en + 1'b1;

  AST_RST_AFTER_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(ep_rst_n) |-> (phy_test_pd && !refclk_en && !train_en)); // R2

  AST_REF_AFTER_POWER: assert property (@(posedge clk) disable iff (rst)
    $rose(refclk_en) |-> (ep_pwr_en && !phy_test_pd && ep_rst_n)); // R4

  AST_CLK_THERMO: assert property (@(posedge clk) disable iff (rst)
    (clk_en_inc & clk_en) == '0); // R5

  AST_TRAIN_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(train_en) |-> ($past(setup_done) && refclk_en && clk_en[NUM_CLKS-1])); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(link_fail) |-> (done && retry_cnt == RETRY_W'(MAX_TRIES))); // R8

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= RETRY_W'(MAX_TRIES)); // R8

endmodule

bind bringup_seq bringup_seq_checker #(
  .MAX_TRIES (MAX_TRIES),
  .NUM_CLKS  (NUM_CLKS)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .setup_done  (setup_done),
  .phy_test_pd (phy_test_pd),
  .refclk_en   (refclk_en),
  .ep_rst_n    (ep_rst_n),
  .ep_pwr_en   (ep_pwr_en),
  .train_en    (train_en),
  .clk_en      (clk_en),
  .done        (done),
  .link_fail   (link_fail),
  .retry_cnt   (retry_cnt)
);

// File: tb/bringup_seq_test.sv
`timescale 1ns/100ps
module bringup_seq_test;

  localparam int HOLD   = 8;
  localparam int SETTLE = 3;
  localparam int POLL   = 4;
  localparam int TRIES  = 10;
  localparam int NCLK   = 4;
  localparam int RW     = $clog2(TRIES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic setup_done = 1'b0;
  logic link_up = 1'b0;
  logic phy_test_pd, refclk_en, ep_rst_n, ep_pwr_en, train_en, done, link_fail;
  logic [NCLK-1:0] clk_en;
  logic [RW-1:0]   retry_cnt;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit tick_on = 1'b1;

  always #2.5 clk = ~clk;

  bringup_seq #(
    .HOLD_TICKS(HOLD), .SETTLE_TICKS(SETTLE), .POLL_TICKS(POLL),
    .MAX_TRIES(TRIES), .NUM_CLKS(NCLK)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .setup_done(setup_done), .link_up(link_up),
    .phy_test_pd(phy_test_pd), .refclk_en(refclk_en), .ep_rst_n(ep_rst_n),
    .ep_pwr_en(ep_pwr_en), .train_en(train_en), .clk_en(clk_en),
    .done(done), .link_fail(link_fail), .retry_cnt(retry_cnt)
  );

  // Reference model: a queue of pending actions consumed at each rising edge.
  // Codes: 1 pd on, 2 train off, 3 ref off, 4 reset low, 5 hold wait,
  // 6 reset high, 7 power on, 8 pd off, 9 ref on, 10+k clock k on,
  // 20 settle wait, 21 wait for setup, 22 polling.
  int  q[$];
  int  tcnt = 0;
  int  m_retry = 0;
  bit  m_pd = 0, m_ref = 0, m_rstn = 1, m_pwr = 0, m_trn = 0, m_done = 0, m_fail = 0;
  int  m_clk = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); tcnt = 0; m_retry = 0;
      m_pd = 0; m_ref = 0; m_rstn = 1; m_pwr = 0; m_trn = 0;
      m_done = 0; m_fail = 0; m_clk = 0;
    end else begin
      m_done = 0;
      if (q.size() == 0) begin
        if (start) begin
          m_fail = 0; m_retry = 0;
          q = {1, 2, 3, 4, 5, 6, 7, 8, 9};
          for (int k = 0; k < NCLK; k++) q.push_back(10 + k);
          q.push_back(20); q.push_back(21); q.push_back(22);
        end
      end else begin
        case (q[0])
          1: begin m_pd = 1; void'(q.pop_front()); end
          2: begin m_trn = 0; void'(q.pop_front()); end
          3: begin m_ref = 0; void'(q.pop_front()); end
          4: begin m_rstn = 0; void'(q.pop_front()); end
          6: begin m_rstn = 1; void'(q.pop_front()); end
          7: begin m_pwr = 1; void'(q.pop_front()); end
          8: begin m_pd = 0; void'(q.pop_front()); end
          9: begin m_ref = 1; void'(q.pop_front()); end
          5, 20: begin
            if (tick) tcnt++;
            if (tcnt == ((q[0] == 5) ? HOLD : SETTLE)) begin
              tcnt = 0; void'(q.pop_front());
            end
          end
          21: if (setup_done) begin m_trn = 1; void'(q.pop_front()); end
          22: begin
            if (tick) tcnt++;
            if (tcnt == POLL) begin
              tcnt = 0;
              if (link_up) begin
                m_done = 1; void'(q.pop_front());
              end else begin
                m_retry++;
                if (m_retry == TRIES) begin
                  m_fail = 1; m_done = 1; void'(q.pop_front());
                end
              end
            end
          end
          default: begin m_clk = m_clk | (1 << (q[0] - 10)); void'(q.pop_front()); end
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Compare every output against the model on each falling edge.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2", "phy_test_pd", phy_test_pd, m_pd);
      chk("R4", "refclk_en", refclk_en, m_ref);
      chk("R3", "ep_rst_n", ep_rst_n, m_rstn);
      chk("R4", "ep_pwr_en", ep_pwr_en, m_pwr);
      chk("R6", "train_en", train_en, m_trn);
      chk("R5", "clk_en", clk_en, m_clk);
      chk("R7", "done", done, m_done);
      chk("R8", "link_fail", link_fail, m_fail);
      chk("R7", "retry_cnt", retry_cnt, m_retry);
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Tick every third cycle while enabled.
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick <= tick_on && (tdiv == 0);
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    int n;
    n = 0;
    while (!done && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "reset phy_test_pd", phy_test_pd, 0);
    chk("R1", "reset ep_rst_n", ep_rst_n, 1);
    chk("R1", "reset outputs", {refclk_en, ep_pwr_en, train_en, done, link_fail}, 0);
    chk("R1", "reset clk_en", clk_en, 0);
    chk("R1", "reset retry_cnt", retry_cnt, 0);
    rst = 1'b0;
    @(negedge clk);

    // Run 1: setup already done, link up at first sample.
    setup_done = 1'b1;
    link_up = 1'b1;
    pulse_start();
    wait_done(2000);
    chk("R7", "run1 done seen", done, 1);
    chk("R7", "run1 retries", retry_cnt, 0);
    @(negedge clk);

    // Run 2: setup arrives late, start repeated mid-run (R9), link after 3 misses.
    setup_done = 1'b0;
    link_up = 1'b0;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (80) @(negedge clk);
    chk("R6", "train held off without setup", train_en, 0);
    setup_done = 1'b1;
    repeat (POLL * 3 * 3 + 6) @(negedge clk);
    link_up = 1'b1;
    wait_done(2000);
    chk("R9", "run2 completed once", done, 1);
    chk("R7", "run2 retries", retry_cnt, 3);
    @(negedge clk);
    chk("R7", "done one cycle", done, 0);

    // Run 3: link never rises.
    link_up = 1'b0;
    pulse_start();
    wait_done(4000);
    chk("R8", "run3 fail", link_fail, 1);
    chk("R8", "run3 retries", retry_cnt, TRIES);
    repeat (20) @(negedge clk);
    chk("R8", "outputs kept", {ep_rst_n, ep_pwr_en, refclk_en, train_en, phy_test_pd}, 5'b11110);
    chk("R8", "clocks kept", clk_en, (1 << NCLK) - 1);

    // Run 4: restart after failure clears the flags.
    link_up = 1'b1;
    pulse_start();
    chk("R9", "restart clears fail", link_fail, 0);
    wait_done(2000);
    chk("R9", "restart completed", done, 1);
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule